// File: doc/BRIEF.md
# Byte and halfword swap unit

This block rearranges the bytes of a 32-bit operand under a two-bit operation select. It can swap the two bytes inside each halfword, reverse the order of all four bytes, or exchange the upper and lower halfwords. Alongside the rearranged word it produces a four-bit condition flag set (zero, sign, carry, overflow) derived from the result. The carry flag marks a zero byte or a zero halfword, so software can use it to spot string terminators or empty fields after the swap.

The datapath is combinational. A parameter chooses whether the result, the flags and a valid strobe are captured in one register stage or passed straight through. The remaining select code passes the operand through and returns the incoming flags unchanged, so a caller can route every word through the unit without changing its condition state.

Top module: `swp_unit`

## Requirements
- R1: With op_sel = 2'b01 the result swaps the two bytes inside each halfword: result bits 7:0 take operand bits 15:8, bits 15:8 take bits 7:0, bits 23:16 take bits 31:24 and bits 31:24 take bits 23:16.
- R2: With op_sel = 2'b10 the result reverses the byte order of the operand: result byte k (bits 8k+7:8k) takes operand byte 3-k.
- R3: With op_sel = 2'b11 the result holds operand bits 15:0 in bits 31:16 and operand bits 31:16 in bits 15:0.
- R4: For op_sel codes 01, 10 and 11 the zero flag (flags_out bit 3) is 1 exactly when the result is zero, and the sign flag (flags_out bit 2) equals result bit 31.
- R5: For op_sel codes 01, 10 and 11 the overflow flag (flags_out bit 1) is 0.
- R6: For op_sel = 2'b01 the carry flag (flags_out bit 0) is 1 exactly when result bits 7:0 are zero.
- R7: For op_sel = 2'b10 the carry flag is 1 exactly when at least one of the four result bytes is zero.
- R8: For op_sel = 2'b11 the carry flag is 1 exactly when result bits 31:16 or result bits 15:0 are zero.
- R9: With op_sel = 2'b00 the result equals the operand and flags_out equals flags_in, bit for bit.
- R10: With REG_OUT = 1 the result and flags of an operand presented with in_valid high appear with out_valid high after the next rising clock edge; with in_valid low, out_valid goes low and result and flags_out hold their previous values.
- R11: With REG_OUT = 0 result and flags_out follow the inputs with no clock edge, and out_valid equals in_valid.
- R12: With REG_OUT = 1, while rst_n is low, out_valid, result and flags_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| op_sel | input | 2 | 00 pass, 01 swap bytes in halfwords, 10 reverse bytes, 11 swap halfwords |
| operand | input | 32 | Word to rearrange |
| flags_in | input | 4 | Current flags {Z,S,OV,CY}, returned on pass-through |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rearranged word |
| flags_out | output | 4 | Updated flags {Z,S,OV,CY} |

## Verification
The bench builds two copies side by side, one with REG_OUT = 1 and one with REG_OUT = 0, and drives both with the same vectors, so each select code is checked at both the combinational and the registered boundary. Operands are built from every combination of five byte values per lane (zero, one, 0x80, 0xFF and 0x5A), which covers every pattern of zero bytes and zero halfwords and both signs of bit 31 for each operation. Flag inputs cycle through all sixteen values to show that only the pass-through code returns them. Separate steps cover the hold behaviour with in_valid low and the reset values of the registered copy.

// File: rtl/swp_pkg.sv
package swp_pkg;

   localparam int WORD_W = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = WORD_W / LANE_W;
   localparam int HALF_W = WORD_W / 2;
   localparam int FLAG_W = 4;
   localparam int OP_W   = 2;

   typedef enum logic [OP_W-1:0] {
      OP_PASS       = 2'b00,
      OP_BSWAP_HALF = 2'b01,
      OP_BREV_WORD  = 2'b10,
      OP_HSWAP      = 2'b11
   } swp_op_e;

   typedef struct packed {
      logic z;
      logic s;
      logic ov;
      logic cy;
   } swp_flags_t;

endpackage

// File: rtl/swp_permute.sv
module swp_permute
   import swp_pkg::*;
(
   input  swp_op_e           op,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int SRC_BH = g ^ 1;
      localparam int SRC_BR = LANES - 1 - g;
      localparam int SRC_HS = g ^ (LANES / 2);

      always_comb begin
         unique case (op)
            OP_BSWAP_HALF: dout[g*LANE_W +: LANE_W] = din[SRC_BH*LANE_W +: LANE_W];
            OP_BREV_WORD:  dout[g*LANE_W +: LANE_W] = din[SRC_BR*LANE_W +: LANE_W];
            OP_HSWAP:      dout[g*LANE_W +: LANE_W] = din[SRC_HS*LANE_W +: LANE_W];
            default:       dout[g*LANE_W +: LANE_W] = din[g*LANE_W +: LANE_W];
         endcase
      end
   end

endmodule

// File: rtl/swp_flags.sv
module swp_flags
   import swp_pkg::*;
(
   input  swp_op_e           op,
   input  logic [WORD_W-1:0] word,
   input  swp_flags_t        flags_in,
   output swp_flags_t        flags_out
);

   logic [LANES-1:0] lane_zero;
   logic             half_lo_zero;
   logic             half_hi_zero;
   logic             cy_sel;

   for (genvar g = 0; g < LANES; g++) begin : g_zero
      assign lane_zero[g] = (word[g*LANE_W +: LANE_W] == '0);
   end

   assign half_lo_zero = &lane_zero[LANES/2-1:0];
   assign half_hi_zero = &lane_zero[LANES-1:LANES/2];

   always_comb begin
      unique case (op)
         OP_BSWAP_HALF: cy_sel = lane_zero[0];
         OP_BREV_WORD:  cy_sel = |lane_zero;
         OP_HSWAP:      cy_sel = half_lo_zero | half_hi_zero;
         default:       cy_sel = 1'b0;
      endcase
   end

   always_comb begin
      if (op == OP_PASS) begin
         flags_out = flags_in;
      end else begin
         flags_out.z  = half_lo_zero & half_hi_zero;
         flags_out.s  = word[WORD_W-1];
         flags_out.ov = 1'b0;
         flags_out.cy = cy_sel;
      end
   end

endmodule

// File: rtl/swp_outstage.sv
module swp_outstage
   import swp_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [WORD_W-1:0] data_i,
   input  swp_flags_t        flags_i,
   output logic              vld_o,
   output logic [WORD_W-1:0] data_o,
   output swp_flags_t        flags_o
);

   if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_o   <= 1'b0;
            data_o  <= '0;
            flags_o <= '0;
         end else begin
            vld_o <= vld_i;
            if (vld_i) begin
               data_o  <= data_i;
               flags_o <= flags_i;
            end
         end
      end

      AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         vld_i |=> (vld_o && data_o == $past(data_i))); // R10
      AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !vld_i |=> (!vld_o && $stable(data_o) && $stable(flags_o))); // R10
   end else begin : g_comb
      assign vld_o   = vld_i;
      assign data_o  = data_i;
      assign flags_o = flags_i;

      AST_COMB_VALID: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_o == vld_i) && (data_o == data_i)); // R11
   end

endmodule

// File: rtl/swp_unit.sv
module swp_unit
   import swp_pkg::*;
#(
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op_sel,
   input  logic [WORD_W-1:0] operand,
   input  logic [FLAG_W-1:0] flags_in,
   output logic              out_valid,
   output logic [WORD_W-1:0] result,
   output logic [FLAG_W-1:0] flags_out
);

   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_cfg
      $error("swp_unit: REG_OUT must be 0 or 1");
   end
   if (LANES != 4 || LANE_W * LANES != WORD_W) begin : g_bad_lanes
      $error("swp_unit: word must split into four byte lanes");
   end

   swp_op_e          op_e;
   logic [WORD_W-1:0] perm_data;
   swp_flags_t       flg_in_s;
   swp_flags_t       flg_calc;
   swp_flags_t       flg_out_s;

   assign op_e     = swp_op_e'(op_sel);
   assign flg_in_s = swp_flags_t'(flags_in);

   swp_permute u_perm (
      .op   (op_e),
      .din  (operand),
      .dout (perm_data)
   );

   swp_flags u_flags (
      .op        (op_e),
      .word      (perm_data),
      .flags_in  (flg_in_s),
      .flags_out (flg_calc)
   );

   swp_outstage #(.REG_OUT(REG_OUT)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (in_valid),
      .data_i  (perm_data),
      .flags_i (flg_calc),
      .vld_o   (out_valid),
      .data_o  (result),
      .flags_o (flg_out_s)
   );

   assign flags_out = flg_out_s;

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e != OP_PASS) |-> (flg_calc.z == (perm_data == '0))); // R4
   AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e != OP_PASS) |-> (flg_calc.s == perm_data[WORD_W-1])); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e != OP_PASS) |-> !flg_calc.ov); // R5
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_PASS) |-> (perm_data == operand && flg_calc == flg_in_s)); // R9
   AST_HSWAP_INVOLUTION: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e == OP_HSWAP) |-> ({perm_data[HALF_W-1:0], perm_data[WORD_W-1:HALF_W]} == operand)); // R3
   AST_ZERO_IMPLIES_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_e inside {OP_BREV_WORD, OP_HSWAP} && flg_calc.z) |-> flg_calc.cy); // R7

endmodule

// File: tb/test_swp_unit.sv
module test_swp_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'b00;
   logic [31:0] operand = '0;
   logic [3:0]  flags_in = '0;

   logic        vld_r, vld_c;
   logic [31:0] res_r, res_c;
   logic [3:0]  flg_r, flg_c;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   swp_unit #(.REG_OUT(1)) i_swp_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .operand(operand), .flags_in(flags_in),
      .out_valid(vld_r), .result(res_r), .flags_out(flg_r)
   );

   swp_unit #(.REG_OUT(0)) i_swp_unit_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .operand(operand), .flags_in(flags_in),
      .out_valid(vld_c), .result(res_c), .flags_out(flg_c)
   );

   function automatic logic [7:0] byte_val(int k);
      case (k)
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h80;
         3: return 8'hFF;
         default: return 8'h5A;
      endcase
   endfunction

   function automatic logic [31:0] exp_data(logic [1:0] op, logic [31:0] x);
      logic [7:0] b0, b1, b2, b3;
      b0 = x[7:0]; b1 = x[15:8]; b2 = x[23:16]; b3 = x[31:24];
      case (op)
         2'b01: return {b2, b3, b0, b1};
         2'b10: return {b0, b1, b2, b3};
         2'b11: return {b1, b0, b3, b2};
         default: return x;
      endcase
   endfunction

   function automatic logic [3:0] exp_flags(logic [1:0] op, logic [31:0] x, logic [3:0] fin);
      logic [31:0] r;
      logic z, s, cy;
      r = exp_data(op, x);
      z = (r == 32'd0);
      s = r[31];
      case (op)
         2'b01: cy = (r[7:0] == 8'd0);
         2'b10: cy = (r[7:0] == 8'd0) || (r[15:8] == 8'd0) || (r[23:16] == 8'd0) || (r[31:24] == 8'd0);
         2'b11: cy = (r[15:0] == 16'd0) || (r[31:16] == 16'd0);
         default: cy = 1'b0;
      endcase
      if (op == 2'b00) return fin;
      return {z, s, 1'b0, cy};
   endfunction

   function automatic string req_of(logic [1:0] op);
      case (op)
         2'b01: return "R1/R4/R5/R6";
         2'b10: return "R2/R4/R5/R7";
         2'b11: return "R3/R4/R5/R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] x;
      logic [31:0] held;
      logic [3:0]  held_f;
      // R12: reset values of the registered copy
      in_valid = 1'b1;
      op_sel = 2'b10;
      operand = 32'h1234_5678;
      repeat (3) @(negedge clk);
      chk("R12 out_valid", {31'd0, vld_r}, 32'd0);
      chk("R12 result", res_r, 32'd0);
      chk("R12 flags", {28'd0, flg_r}, 32'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int a = 0; a < 5; a++)
         for (int b = 0; b < 5; b++)
            for (int c = 0; c < 5; c++)
               for (int d = 0; d < 5; d++)
                  for (int op = 0; op < 4; op++) begin
                     x = {byte_val(d), byte_val(c), byte_val(b), byte_val(a)};
                     in_valid = 1'b1;
                     op_sel   = 2'(op);
                     operand  = x;
                     flags_in = 4'((a + 3*b + 5*c + 7*d + op) & 15);
                     #1;
                     // R11: combinational copy answers without a clock edge
                     chk({req_of(op_sel), " R11 data"}, res_c, exp_data(op_sel, x));
                     chk({req_of(op_sel), " R11 flags"}, {28'd0, flg_c}, {28'd0, exp_flags(op_sel, x, flags_in)});
                     chk("R11 valid", {31'd0, vld_c}, 32'd1);
                     @(negedge clk);
                     // R10: registered copy one edge later
                     chk({req_of(op_sel), " R10 data"}, res_r, exp_data(op_sel, x));
                     chk({req_of(op_sel), " R10 flags"}, {28'd0, flg_r}, {28'd0, exp_flags(op_sel, x, flags_in)});
                     chk("R10 valid", {31'd0, vld_r}, 32'd1);
                  end

      // R10: hold with in_valid low
      held   = res_r;
      held_f = flg_r;
      in_valid = 1'b0;
      op_sel   = 2'b01;
      operand  = 32'hDEAD_BEEF;
      flags_in = 4'hA;
      #1;
      chk("R11 valid low", {31'd0, vld_c}, 32'd0);
      @(negedge clk);
      chk("R10 valid low", {31'd0, vld_r}, 32'd0);
      chk("R10 hold data", res_r, held);
      chk("R10 hold flags", {28'd0, flg_r}, {28'd0, held_f});
      @(negedge clk);
      chk("R10 hold data 2", res_r, held);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule